// File: doc/BRIEF.md
# Multi-Mode Test Response Compactor

This block folds the response stream of a circuit under test into a short signature that a self-test controller can compare against a known-good value. A two-bit mode input picks one of four compaction schemes: counting the ones in a serial stream, counting the level changes in a serial stream, or dividing the response by a characteristic polynomial in a modular shift register. The division is fed either one serial bit per step or one parallel word per step.

Only cycles with the data-valid strobe high advance the compactor. A synchronous clear starts a new run. A done strobe latches a pass/fail verdict that compares the current signature with an expected value supplied on an input. Different fault responses alias under different schemes, so a controller can choose the scheme that suits the circuit it tests.

Top module: `resp_compactor`

## Requirements
- R1: With mode 0 (ones), the signature is the number of valid cycles on which the serial bit was 1 since the last clear.
- R2: With mode 1 (transitions), the signature is the number of valid cycles on which the serial bit differs from the serial bit of the previous valid cycle. Changes from 0 to 1 and from 1 to 0 both count. The first valid bit after a clear or reset is never counted.
- R3: With mode 2 (serial division), the register holds the remainder of M(x) divided by f(x) = 1 + x + x^4 by default. Signature bit i is the coefficient of x^i. The first valid serial bit is the highest-degree coefficient of M(x).
- R4: With mode 3 (parallel division), each valid word D is folded in as S := (S·x mod f(x)) XOR D, with word bit i added to stage i.
- R5: On cycles with valid low, the signature does not change, whatever the serial and parallel inputs do.
- R6: A synchronous clear, or the active-low asynchronous reset, sets the signature to 0 and drops the verdict-valid output.
- R7: The ones and transition counters saturate at 2^CNT_W − 1 and never wrap. CNT_W is ceil(log2(MAX_LEN+1)).
- R8: One cycle after a done strobe, verdict-valid is 1 and pass equals (signature == expected).
- R9: In modes 0 and 1 the signature output shows the counter, zero-extended. In modes 2 and 3 it shows the division register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear that starts a new run |
| mode | input | 2 | Scheme select: 0 ones, 1 transitions, 2 serial division, 3 parallel division |
| valid | input | 1 | Response sample strobe |
| ser_in | input | 1 | Serial response bit |
| par_in | input | SIG_W | Parallel response word |
| done | input | 1 | Latch a pass/fail verdict |
| expect_sig | input | OUT_W | Expected good signature |
| sig_out | output | OUT_W | Current signature |
| pass | output | 1 | Signature matched the expected value at the last done |
| pass_vld | output | 1 | Verdict is valid |

## Verification
The bench builds the block with SIG_W=4, POLY=4'b0011 and MAX_LEN=15, so the counters are 4 bits wide. This lets sixteen ones reach saturation within a short run. The 4-stage register keeps every remainder small enough to work out by hand. The responses come from a 3-bit exhaustive pattern counter. The division results are cross-checked against long division in the bench, and one scheme is shown to alias a faulty response that another scheme separates.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        MODE_ONES  = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_SISR  = 2'd2,
        MODE_MISR  = 2'd3
    } rc_mode_e;
endpackage

// File: rtl/rc_event_counter.sv
module rc_event_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic             en,
    input  logic             trans_mode,
    input  logic             din,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             first;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       inc;

    always_comb begin
        st_d = st_q;
        inc  = 1'b0;
        if (clr) begin
            st_d.cnt   = '0;
            st_d.prev  = 1'b0;
            st_d.first = 1'b1;
        end else if (valid && en) begin
            if (trans_mode) begin
                inc        = st_q.first ? 1'b0 : (din ^ st_q.prev);
                st_d.prev  = din;
                st_d.first = 1'b0;
            end else begin
                inc = din;
            end
            if (inc && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.prev  <= 1'b0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !valid) |=> $stable(count)); // R5
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R7
    AST_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && en && trans_mode && st_q.first) |=> $stable(count)); // R2
    AST_ONES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && en && !trans_mode && count != CNT_MAX)
        |=> (count == $past(count) + CNT_W'($past(din)))); // R1
endmodule

// File: rtl/rc_sig_reg.sv
module rc_sig_reg #(
    parameter int               SIG_W = 4,
    parameter logic [SIG_W-1:0] POLY  = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic             en,
    input  logic             par_mode,
    input  logic             ser_in,
    input  logic [SIG_W-1:0] par_in,
    output logic [SIG_W-1:0] sig
);
    typedef struct packed {
        logic [SIG_W-1:0] r;
    } sig_state_t;

    sig_state_t       st_d, st_q;
    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] inject;
    logic             fb;

    assign fb = st_q.r[SIG_W-1];

    genvar g;
    generate
        for (g = 0; g < SIG_W; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign shifted[g] = POLY[g] & fb;
            end else begin : g_body
                assign shifted[g] = st_q.r[g-1] ^ (POLY[g] & fb);
            end
        end
    endgenerate

    always_comb begin
        inject    = '0;
        inject[0] = ser_in;
        if (par_mode) begin
            inject = par_in;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.r = '0;
        end else if (valid && en) begin
            st_d.r = shifted ^ inject;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.r <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig = st_q.r;

    AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !valid) |=> $stable(sig)); // R5
    AST_SIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig == '0)); // R6
    AST_SER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && en && !par_mode)
        |=> (sig[0] == ($past(sig[SIG_W-1]) ^ $past(ser_in)))); // R3
    AST_PAR_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && valid && en && par_mode)
        |=> (sig[0] == ($past(sig[SIG_W-1]) ^ $past(par_in[0])))); // R4
endmodule

// File: rtl/rc_sig_check.sv
module rc_sig_check #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         done,
    input  logic [W-1:0] sig,
    input  logic [W-1:0] expect_sig,
    output logic         pass,
    output logic         pass_vld
);
    typedef struct packed {
        logic pass;
        logic vld;
    } chk_state_t;

    chk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld  = 1'b0;
            st_d.pass = 1'b0;
        end else if (done) begin
            st_d.vld  = 1'b1;
            st_d.pass = (sig == expect_sig);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pass     = st_q.pass;
    assign pass_vld = st_q.vld;

    AST_VERDICT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && done) |=> pass_vld); // R8
    AST_VERDICT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pass_vld); // R6
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor #(
    parameter int               SIG_W   = 4,
    parameter logic [SIG_W-1:0] POLY    = 4'b0011,
    parameter int               MAX_LEN = 255,
    localparam int              CNT_W   = $clog2(MAX_LEN + 1),
    localparam int              OUT_W   = (CNT_W > SIG_W) ? CNT_W : SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       mode,
    input  logic             valid,
    input  logic             ser_in,
    input  logic [SIG_W-1:0] par_in,
    input  logic             done,
    input  logic [OUT_W-1:0] expect_sig,
    output logic [OUT_W-1:0] sig_out,
    output logic             pass,
    output logic             pass_vld
);
    import rc_pkg::*;

    rc_mode_e         mode_e;
    logic             cnt_en;
    logic             div_en;
    logic [CNT_W-1:0] count;
    logic [SIG_W-1:0] div_sig;
    logic [OUT_W-1:0] sig_d;

    assign mode_e = rc_mode_e'(mode);
    assign cnt_en = (mode_e == MODE_ONES) || (mode_e == MODE_TRANS);
    assign div_en = (mode_e == MODE_SISR) || (mode_e == MODE_MISR);

    rc_event_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .valid      (valid),
        .en         (cnt_en),
        .trans_mode (mode_e == MODE_TRANS),
        .din        (ser_in),
        .count      (count)
    );

    rc_sig_reg #(.SIG_W(SIG_W), .POLY(POLY)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .valid    (valid),
        .en       (div_en),
        .par_mode (mode_e == MODE_MISR),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .sig      (div_sig)
    );

    always_comb begin
        sig_d = '0;
        if (cnt_en) begin
            sig_d[CNT_W-1:0] = count;
        end else begin
            sig_d[SIG_W-1:0] = div_sig;
        end
    end

    assign sig_out = sig_d;

    rc_sig_check #(.W(OUT_W)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .done       (done),
        .sig        (sig_d),
        .expect_sig (expect_sig),
        .pass       (pass),
        .pass_vld   (pass_vld)
    );

    AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $stable(mode)) |=> (sig_out == '0)); // R6
endmodule

// File: tb/resp_compactor_bench.sv
`timescale 1ns/1ps
module resp_compactor_bench;
    localparam int SIG_W = 4;
    localparam int OUT_W = 4;
    localparam logic [4:0] FULL_POLY = 5'b10011;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             valid = 1'b0;
    logic             ser_in = 1'b0;
    logic [SIG_W-1:0] par_in = '0;
    logic             done = 1'b0;
    logic [OUT_W-1:0] expect_sig = '0;
    logic [OUT_W-1:0] sig_out;
    logic             pass;
    logic             pass_vld;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    resp_compactor #(.SIG_W(4), .POLY(4'b0011), .MAX_LEN(15)) u_resp_compactor (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .valid(valid),
        .ser_in(ser_in), .par_in(par_in), .done(done), .expect_sig(expect_sig),
        .sig_out(sig_out), .pass(pass), .pass_vld(pass_vld)
    );

    // row = {mode, response stream (first pattern at bit 7), expected}
    localparam logic [13:0] TBL [12] = '{
        {2'd0, 8'b01000111, 4'd4},  {2'd0, 8'b01110111, 4'd6},
        {2'd0, 8'b11111111, 4'd8},  {2'd0, 8'b00001111, 4'd4},
        {2'd1, 8'b01000111, 4'd3},  {2'd1, 8'b01110111, 4'd3},
        {2'd1, 8'b11111111, 4'd0},  {2'd1, 8'b00001111, 4'd1},
        {2'd2, 8'b01000111, 4'b1011}, {2'd2, 8'b01110111, 4'b1110},
        {2'd2, 8'b11111111, 4'b1101}, {2'd2, 8'b00001111, 4'b1111}
    };
    localparam string REQ_OF_MODE [3] = '{"R1", "R2", "R3"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1; valid = 1'b0;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic feed_bit(input logic b);
        @(negedge clk); valid = 1'b1; ser_in = b;
    endtask

    task automatic feed_word(input logic [SIG_W-1:0] w);
        @(negedge clk); valid = 1'b1; par_in = w;
    endtask

    task automatic idle();
        @(negedge clk); valid = 1'b0;
    endtask

    function automatic logic [3:0] long_div(input logic [7:0] m);
        logic [7:0] r = m;
        for (int d = 7; d >= 4; d--) begin
            if (r[d]) r = r ^ (8'(FULL_POLY) << (d - 4));
        end
        return r[3:0];
    endfunction

    function automatic logic [3:0] times_x(input logic [3:0] a);
        logic [4:0] t = {a, 1'b0};
        if (t[4]) t = t ^ FULL_POLY;
        return t[3:0];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] model;
        logic [3:0] w;
        // reset state, R6
        repeat (3) @(negedge clk);
        chk("R6 reset sig", 32'(sig_out), 0);
        chk("R6 reset verdict", 32'(pass_vld), 0);
        rst_n = 1'b1;

        // table walk: stimulus from a 3-bit exhaustive pattern counter
        for (int i = 0; i < 12; i++) begin
            mode = TBL[i][13:12];
            do_clear();
            for (int pat = 0; pat < 8; pat++) feed_bit(TBL[i][4 + 7 - pat]);
            idle();
            chk(REQ_OF_MODE[TBL[i][13:12]], 32'(sig_out), 32'(TBL[i][3:0]));
            if (TBL[i][13:12] == 2'd2)
                chk("R3 long division", 32'(sig_out), 32'(long_div(TBL[i][11:4])));
        end

        // aliasing: transitions alias 01110111 with the good response, division does not
        chk("R2 alias", 32'(TBL[5][3:0] == TBL[4][3:0]), 1);
        chk("R3 no alias", 32'(long_div(8'b01110111) != long_div(8'b01000111)), 1);

        // R8 verdict: last run is serial division of 00001111 -> 1111
        @(negedge clk); expect_sig = 4'b1111; done = 1'b1;
        @(negedge clk); done = 1'b0;
        chk("R8 pass vld", 32'(pass_vld), 1);
        chk("R8 pass match", 32'(pass), 1);
        @(negedge clk); expect_sig = 4'b0110; done = 1'b1;
        @(negedge clk); done = 1'b0;
        chk("R8 pass mismatch", 32'(pass), 0);
        do_clear();
        chk("R6 clear verdict", 32'(pass_vld), 0);
        chk("R6 clear sig", 32'(sig_out), 0);

        // R4 parallel division, words from the pattern counter
        for (int run = 0; run < 2; run++) begin
            mode = 2'd3;
            do_clear();
            model = '0;
            for (int pat = 0; pat < 8; pat++) begin
                w = {pat[2] ^ pat[0], pat[2:0]};
                if (run == 1) w = ~w;
                model = times_x(model) ^ w;
                feed_word(w);
            end
            idle();
            chk("R4 parallel", 32'(sig_out), 32'(model));
        end

        // R5 inputs ignored while valid is low
        model = sig_out;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); par_in = 4'(k * 5); ser_in = k[0];
        end
        @(negedge clk);
        chk("R5 hold parallel", 32'(sig_out), 32'(model));
        mode = 2'd0;
        do_clear();
        feed_bit(1'b1); idle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); ser_in = ~ser_in;
        end
        chk("R5 hold ones", 32'(sig_out), 1);

        // R7 saturation: 16 ones with a 4-bit counter
        do_clear();
        for (int k = 0; k < 16; k++) feed_bit(1'b1);
        idle();
        chk("R7 saturate", 32'(sig_out), 15);

        // R2 first bit after clear never counts
        mode = 2'd1;
        do_clear();
        feed_bit(1'b1); idle();
        chk("R2 first bit", 32'(sig_out), 0);
        feed_bit(1'b0); feed_bit(1'b1); idle();
        chk("R2 both edges", 32'(sig_out), 2);

        // R9 output view follows mode (counter in 1, division register in 2)
        mode = 2'd2;
        @(negedge clk);
        chk("R9 view division", 32'(sig_out), 0);
        mode = 2'd1;
        @(negedge clk);
        chk("R9 view counter", 32'(sig_out), 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule